// File: doc/BRIEF.md
# Basic-Block Control-Flow Integrity Monitor

This block sits beside a processor and watches two event streams: the program counter of each retired instruction and the address of each store write. Software first loads a table that splits the program into basic blocks. Each table slot has three fields:

- a valid bit;
- a start address, called the label;
- a body length.

A block covers every address from its label through label plus length. The last address of that range holds the block's final instruction, called the tail. Once the table is armed, the monitor checks every event against all slots in parallel. It raises a violation in four cases: execution wanders outside the declared blocks, execution leaves a tail for an address that is not a label, a store lands on code, or two blocks share an address.

The violation flag is sticky until reset. A cause code records the first problem found. The monitor does not look at instruction contents. It only enforces the declared decomposition over time. A typical use is to load the slots while unarmed, pulse the arm input once, and then let the processor run.

Top module: `cfi_monitor`

## Requirements
- R1: After reset, `violation` is 0, `cause` is 0 (none), every table slot is invalid and the monitor is unarmed.
- R2: A valid slot with label L and length N covers addresses L through L+N inclusive, computed without wrap. A length of 0 gives a one-instruction block. A retired PC inside any valid slot raises nothing by itself.
- R3: When armed, a retired PC that lies inside no valid slot sets cause 1 (stray PC).
- R4: When armed, after a retired PC that equals the tail address (L+N) of a valid slot, the next retired PC must equal the label of a valid slot; otherwise cause 2 (bad successor) is set. After a non-tail PC, any covered PC may follow.
- R5: When armed, a write whose address lies inside any valid slot's range sets cause 3 (code write). Writes outside every range raise nothing.
- R6: On the arm pulse, if any two valid slots share at least one address, cause 4 (overlap) is set. Adjacent ranges do not overlap.
- R7: `violation` is sticky until reset, and `cause` keeps the first value recorded.
- R8: When several causes arise in the same cycle, the priority is stray PC, then bad successor, then code write.
- R9: Events are ignored before arming. Table writes after arming are ignored. Invalid slots take part in no check.
- R10: A violation appears on the outputs at the clock edge that samples the offending event (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one table slot (unarmed only) |
| cfg_idx | input | 4 | Slot index to write |
| cfg_valid | input | 1 | Valid bit for the slot |
| cfg_label | input | 16 | Block start address |
| cfg_len | input | 8 | Body length; the tail sits at label plus length |
| arm | input | 1 | Pulse to freeze the table, run the overlap check and start monitoring |
| retire_valid | input | 1 | A retired PC is presented |
| retire_pc | input | 16 | Retired program counter |
| wr_en | input | 1 | A store write is presented |
| wr_addr | input | 16 | Store write address |
| violation | output | 1 | Sticky violation flag |
| cause | output | 3 | First cause: 0 none, 1 stray PC, 2 bad successor, 3 code write, 4 overlap |

## Verification
The assertions check the following on every cycle:

- the flag stays set once raised;
- the cause stays frozen once recorded;
- the cause is zero while the flag is clear;
- a violation rises only after a sampled event;
- an overlap cause rises only after an arm pulse;
- any other cause rises only while armed.

The following depend on table contents and event order, so only the bench scenarios can show them:

- which cause a given PC or write produces;
- the inclusive range ends and the empty-body block;
- the successor rule after a tail;
- the same-cycle priority;
- that late table writes and invalid slots are ignored.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
    localparam int NUM_BLOCKS = 16;
    localparam int ADDR_W     = 16;
    localparam int LEN_W      = 8;
    localparam int IDX_W      = $clog2(NUM_BLOCKS);
    localparam int CAUSE_W    = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ADDR_W:0]   span_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_STRAY_PC   = 3'd1,
        CAUSE_BAD_SUCC   = 3'd2,
        CAUSE_CODE_WRITE = 3'd3,
        CAUSE_OVERLAP    = 3'd4
    } cause_e;

    typedef struct packed {
        logic  valid;
        addr_t label;
        len_t  len;
    } blk_entry_t;

    function automatic span_t span_lo(blk_entry_t e);
        return {1'b0, e.label};
    endfunction

    function automatic span_t span_hi(blk_entry_t e);
        return {1'b0, e.label} + span_t'(e.len);
    endfunction

    function automatic logic covers(blk_entry_t e, addr_t a);
        return e.valid && (span_t'(a) >= span_lo(e)) && (span_t'(a) <= span_hi(e));
    endfunction
endpackage

// File: rtl/cfi_table.sv
module cfi_table
    import cfi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  blk_entry_t       cfg_entry,
    input  logic             arm,
    output blk_entry_t       tbl [NUM_BLOCKS],
    output logic             armed,
    output logic             arm_now
);
    assign arm_now = arm && !armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (arm_now) begin
            armed <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[i] <= '0;
            end else if (cfg_we && !armed && (cfg_idx == IDX_W'(i))) begin
                tbl[i] <= cfg_entry;
            end
        end
    end
endmodule

// File: rtl/cfi_match.sv
module cfi_match
    import cfi_pkg::*;
(
    input  blk_entry_t tbl [NUM_BLOCKS],
    input  addr_t      pc,
    input  addr_t      waddr,
    output logic       pc_in,
    output logic       pc_label,
    output logic       pc_tail,
    output logic       wr_in
);
    logic [NUM_BLOCKS-1:0] hit_pc, hit_lbl, hit_tail, hit_wr;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cmp
        assign hit_pc[i]   = covers(tbl[i], pc);
        assign hit_wr[i]   = covers(tbl[i], waddr);
        assign hit_lbl[i]  = tbl[i].valid && (pc == tbl[i].label);
        assign hit_tail[i] = tbl[i].valid && (span_t'(pc) == span_hi(tbl[i]));
    end

    assign pc_in    = |hit_pc;
    assign pc_label = |hit_lbl;
    assign pc_tail  = |hit_tail;
    assign wr_in    = |hit_wr;
endmodule

// File: rtl/cfi_overlap.sv
module cfi_overlap
    import cfi_pkg::*;
(
    input  blk_entry_t tbl [NUM_BLOCKS],
    output logic       overlap
);
    localparam int NPAIR = NUM_BLOCKS * NUM_BLOCKS;
    logic [NPAIR-1:0] clash;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_a
        for (genvar j = 0; j < NUM_BLOCKS; j++) begin : g_b
            if (j > i) begin : g_pair
                assign clash[i*NUM_BLOCKS+j] = tbl[i].valid && tbl[j].valid
                    && (span_lo(tbl[i]) <= span_hi(tbl[j]))
                    && (span_lo(tbl[j]) <= span_hi(tbl[i]));
            end else begin : g_none
                assign clash[i*NUM_BLOCKS+j] = 1'b0;
            end
        end
    end

    assign overlap = |clash;
endmodule

// File: rtl/cfi_monitor.sv
module cfi_monitor
    import cfi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_idx,
    input  logic        cfg_valid,
    input  logic [15:0] cfg_label,
    input  logic [7:0]  cfg_len,
    input  logic        arm,
    input  logic        retire_valid,
    input  logic [15:0] retire_pc,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    output logic        violation,
    output logic [2:0]  cause
);
    blk_entry_t tbl [NUM_BLOCKS];
    blk_entry_t cfg_entry;
    logic       armed, arm_now, overlap;
    logic       pc_in, pc_label, pc_tail, wr_in;
    logic       after_tail;
    cause_e     cause_next;

    assign cfg_entry = '{valid: cfg_valid, label: cfg_label, len: cfg_len};

    cfi_table i_table (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_entry(cfg_entry), .arm(arm), .tbl(tbl),
        .armed(armed), .arm_now(arm_now)
    );

    cfi_match i_match (
        .tbl(tbl), .pc(retire_pc), .waddr(wr_addr),
        .pc_in(pc_in), .pc_label(pc_label), .pc_tail(pc_tail), .wr_in(wr_in)
    );

    cfi_overlap i_overlap (.tbl(tbl), .overlap(overlap));

    always_comb begin
        cause_next = CAUSE_NONE;
        if (arm_now && overlap) begin
            cause_next = CAUSE_OVERLAP;
        end else if (armed) begin
            if (retire_valid && !pc_in) begin
                cause_next = CAUSE_STRAY_PC;
            end else if (retire_valid && after_tail && !pc_label) begin
                cause_next = CAUSE_BAD_SUCC;
            end else if (wr_en && wr_in) begin
                cause_next = CAUSE_CODE_WRITE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            after_tail <= 1'b0;
        end else if (armed && retire_valid) begin
            after_tail <= pc_tail;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            violation <= 1'b0;
            cause     <= CAUSE_NONE;
        end else if (!violation && (cause_next != CAUSE_NONE)) begin
            violation <= 1'b1;
            cause     <= cause_next;
        end
    end
endmodule

// File: rtl/cfi_monitor_chk.sv
module cfi_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       arm,
    input logic       armed,
    input logic       retire_valid,
    input logic       wr_en,
    input logic       violation,
    input logic [2:0] cause
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation); // R7
    AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        violation |=> $stable(cause)); // R7
    AST_CLEAR_MEANS_NONE: assert property (@(posedge clk) disable iff (rst)
        !violation |-> (cause == 3'd0)); // R1
    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(violation) |-> $past(retire_valid || wr_en || arm)); // R10
    AST_OVERLAP_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
        ($rose(violation) && cause == 3'd4) |-> $past(arm)); // R6
    AST_EVENTS_NEED_ARM: assert property (@(posedge clk) disable iff (rst)
        ($rose(violation) && cause != 3'd4) |-> $past(armed)); // R9
endmodule

bind cfi_monitor cfi_monitor_chk i_chk (
    .clk(clk), .rst(rst), .arm(arm), .armed(armed),
    .retire_valid(retire_valid), .wr_en(wr_en),
    .violation(violation), .cause(cause)
);

// File: tb/test_cfi_monitor.sv
`timescale 1ns/1ps
module test_cfi_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_valid = 1'b0, arm = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [15:0] cfg_label = '0;
    logic [7:0]  cfg_len = '0;
    logic        retire_valid = 1'b0, wr_en = 1'b0;
    logic [15:0] retire_pc = '0, wr_addr = '0;
    logic        violation;
    logic [2:0]  cause;

    typedef struct {
        logic       v;
        logic [2:0] c;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    cfi_monitor i_cfi_monitor (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_label(cfg_label), .cfg_len(cfg_len),
        .arm(arm), .retire_valid(retire_valid), .retire_pc(retire_pc),
        .wr_en(wr_en), .wr_addr(wr_addr), .violation(violation), .cause(cause)
    );

    // monitor: compare registered outputs at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (violation !== e.v || cause !== e.c) begin
                    fails++;
                    $display("FAIL %s: got violation=%0b cause=%0d, expected violation=%0b cause=%0d",
                             e.tag, violation, cause, e.v, e.c);
                end
            end
        end
    end

    task automatic clear_inputs();
        cfg_we = 0; arm = 0; retire_valid = 0; wr_en = 0;
    endtask

    task automatic expect_after(input logic v, input logic [2:0] c, input string tag);
        @(posedge clk);
        #1;
        q.push_back('{v: v, c: c, tag: tag});
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        expect_after(1'b0, 3'd0, "R1 reset state");
    endtask

    task automatic cfg(input int idx, input logic valid, input logic [15:0] label,
                       input logic [7:0] len, input string tag);
        @(negedge clk);
        clear_inputs();
        cfg_we = 1; cfg_idx = 4'(idx); cfg_valid = valid; cfg_label = label; cfg_len = len;
        expect_after(1'b0, 3'd0, tag);
    endtask

    task automatic arm_it(input logic v, input logic [2:0] c, input string tag);
        @(negedge clk);
        clear_inputs();
        arm = 1;
        expect_after(v, c, tag);
    endtask

    task automatic ev(input logic rv, input logic [15:0] pc, input logic we,
                      input logic [15:0] wa, input logic v, input logic [2:0] c,
                      input string tag);
        @(negedge clk);
        clear_inputs();
        retire_valid = rv; retire_pc = pc; wr_en = we; wr_addr = wa;
        expect_after(v, c, tag);
    endtask

    task automatic retire(input logic [15:0] pc, input logic v, input logic [2:0] c,
                          input string tag);
        ev(1'b1, pc, 1'b0, 16'h0, v, c, tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic v, input logic [2:0] c,
                      input string tag);
        ev(1'b0, 16'h0, 1'b1, a, v, c, tag);
    endtask

    // blocks: 0x10..0x13, single 0x20, 0x30..0x32
    task automatic load_abc();
        cfg(0, 1'b1, 16'h0010, 8'd3, "R2 load A");
        cfg(1, 1'b1, 16'h0020, 8'd0, "R2 load B");
        cfg(2, 1'b1, 16'h0030, 8'd2, "R2 load C");
    endtask

    initial begin
        do_reset();
        load_abc();
        arm_it(1'b0, 3'd0, "R6 disjoint table arms clean");
        retire(16'h0010, 1'b0, 3'd0, "R2 label of A");
        retire(16'h0011, 1'b0, 3'd0, "R2 body of A");
        retire(16'h0012, 1'b0, 3'd0, "R4 non-tail fall-through");
        retire(16'h0013, 1'b0, 3'd0, "R2 inclusive tail of A");
        retire(16'h0020, 1'b0, 3'd0, "R4 tail to label, empty body B");
        retire(16'h0030, 1'b0, 3'd0, "R4 B tail to label of C");
        retire(16'h0031, 1'b0, 3'd0, "R2 body of C");
        wr(16'h0050, 1'b0, 3'd0, "R5 data write");
        wr(16'h0014, 1'b0, 3'd0, "R5 write just past A");
        cfg(3, 1'b1, 16'h0040, 8'd0, "R9 late table write");
        retire(16'h0040, 1'b1, 3'd1, "R9 late slot ignored, R3 stray");
        wr(16'h0010, 1'b1, 3'd1, "R7 first cause kept");
        retire(16'h0099, 1'b1, 3'd1, "R7 still sticky");

        do_reset();
        load_abc();
        arm_it(1'b0, 3'd0, "R6 arm");
        retire(16'h0012, 1'b0, 3'd0, "R2 body");
        retire(16'h0013, 1'b0, 3'd0, "R2 tail");
        retire(16'h0031, 1'b1, 3'd2, "R4 tail to non-label");

        do_reset();
        load_abc();
        arm_it(1'b0, 3'd0, "R6 arm");
        wr(16'h0020, 1'b1, 3'd3, "R5 write to one-instruction block");

        do_reset();
        load_abc();
        arm_it(1'b0, 3'd0, "R6 arm");
        wr(16'h0032, 1'b1, 3'd3, "R5 write to last code address");

        do_reset();
        cfg(0, 1'b1, 16'h0010, 8'd3, "R2 load A");
        cfg(5, 1'b1, 16'h0014, 8'd1, "R6 load adjacent D");
        arm_it(1'b0, 3'd0, "R6 adjacent ranges accepted");
        retire(16'h0015, 1'b0, 3'd0, "R2 tail of D");

        do_reset();
        cfg(0, 1'b1, 16'h0010, 8'd3, "R2 load A");
        cfg(9, 1'b1, 16'h0013, 8'd0, "R6 load overlapping");
        arm_it(1'b1, 3'd4, "R6 overlap detected");

        do_reset();
        load_abc();
        retire(16'h0099, 1'b0, 3'd0, "R9 stray ignored unarmed");
        wr(16'h0010, 1'b0, 3'd0, "R9 code write ignored unarmed");
        arm_it(1'b0, 3'd0, "R6 arm");
        ev(1'b1, 16'h0099, 1'b1, 16'h0011, 1'b1, 3'd1, "R8 stray beats code write");

        do_reset();
        load_abc();
        arm_it(1'b0, 3'd0, "R6 arm");
        retire(16'h0013, 1'b0, 3'd0, "R2 tail");
        ev(1'b1, 16'h0011, 1'b1, 16'h0030, 1'b1, 3'd2, "R8 bad successor beats code write");

        do_reset();
        cfg(0, 1'b0, 16'h0010, 8'd3, "R9 invalid slot");
        cfg(1, 1'b1, 16'h0020, 8'd0, "R2 load B");
        arm_it(1'b0, 3'd0, "R6 arm");
        wr(16'h0011, 1'b0, 3'd0, "R9 invalid slot not code");
        retire(16'h0011, 1'b1, 3'd1, "R9 invalid slot, R3 stray");

        @(negedge clk);
        clear_inputs();
        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule